// File: doc/BRIEF.md
# DRAM ECC Error Logging Registers

This block is the error-logging register file next to a memory controller's ECC path. It receives error pulses from the controller: a correctable (single-bit) and an uncorrectable (multi-bit) ECC event, which share one 33-bit physical address, a channel bit and an 8-bit syndrome. It also receives three unrelated event pulses: a refresh timeout, a locked access that targets non-DRAM space, and a thermal sensor trip. Each event sets a sticky flag in a 16-bit status word. Software clears a flag by writing 1 to it.

For ECC events the block keeps one record: the address at 128-byte granularity, the channel and the syndrome. The first correctable error fills the record. Later correctable errors only set their flag. An uncorrectable error displaces a logged correctable error, but it does not displace an earlier uncorrectable one. A 16-bit enable word selects which flags drive a registered system-error output. All state is reached through a simple word-addressed read/write port with combinational read data.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every readable register reads 0 and `serr_o` is 0.
- R2: The status word is at offset 0. Correctable ECC sets bit 0, uncorrectable ECC sets bit 1, refresh timeout sets bit 8, the non-DRAM lock event sets bit 9 and the thermal event sets bit 11. Every other bit always reads 0, even after a write of 1s.
- R3: A write to offset 0 clears each flag whose write-data bit is 1. A flag whose write-data bit is 0 keeps its value.
- R4: When an event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R5: Offset 2 reads the logged address bits 31:7 in bits 31:7, reads 0 in bits 6:1, and reads the logged channel in bit 0.
- R6: Offset 3 reads logged address bit 32 in bit 0 and reads 0 in bits 31:1.
- R7: Offset 4 reads the logged 8-bit syndrome in bits 7:0 and reads 0 above.
- R8: A correctable error is logged only when neither ECC flag is set. Otherwise it sets bit 0 and leaves the record unchanged.
- R9: An uncorrectable error replaces the record unless bit 1 is already set. In that case it leaves the record unchanged.
- R10: The enable word is at offset 1. Only bits 0, 1, 8, 9 and 11 hold a written value, and the others read 0.
- R11: `serr_o` is the OR over all flag positions of (flag AND enable), taken from the previous cycle, so it rises one cycle after the flag is set.
- R12: Writes to offsets 2, 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Correctable ECC error pulse |
| ue_i | input | 1 | Uncorrectable ECC error pulse |
| err_addr_i | input | 33 | Physical address of the ECC error |
| err_chan_i | input | 1 | Channel of the ECC error |
| err_syn_i | input | 8 | ECC syndrome |
| rfto_i | input | 1 | Refresh timeout event |
| lock_i | input | 1 | Locked access to non-DRAM space |
| therm_i | input | 1 | Thermal sensor event |
| reg_addr_i | input | 3 | Register word offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| serr_o | output | 1 | Registered system-error output |

## Verification
The hardest situations to reach from the ports are the ordering cases around the single error record. These are a correctable error that lands while a record is already held, an uncorrectable error that lands on a correctable record, and a second uncorrectable error. In each case only the read-back values show whether the record moved. The stimulus table runs a fixed sequence of events with distinct addresses, channels and syndromes, and clears the flags only between groups. After every event it reads the status word and all three record registers. Directed tests then force a set and a clear of the same flag into one cycle. They also sample `serr_o` in the cycle the flag appears and in the following cycle.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
  localparam int STAT_W   = 16;
  localparam int PADDR_W  = 33;
  localparam int SYN_W    = 8;

  localparam int BIT_CE    = 0;
  localparam int BIT_UE    = 1;
  localparam int BIT_RFTO  = 8;
  localparam int BIT_LOCK  = 9;
  localparam int BIT_THERM = 11;

  localparam logic [STAT_W-1:0] FLAG_MASK =
    STAT_W'((1 << BIT_CE) | (1 << BIT_UE) | (1 << BIT_RFTO) |
            (1 << BIT_LOCK) | (1 << BIT_THERM));

  localparam int OFS_STAT  = 0;
  localparam int OFS_CMD   = 1;
  localparam int OFS_EADDR = 2;
  localparam int OFS_EXT   = 3;
  localparam int OFS_SYN   = 4;

  typedef struct packed {
    logic [PADDR_W-1:0] addr;
    logic               chan;
    logic [SYN_W-1:0]   syn;
  } err_info_t;
endpackage

// File: rtl/ecc_err_status.sv
module ecc_err_status
  import ecc_err_log_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (FLAG_MASK[b]) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= set_i[b] | (flag_q & ~clr_i[b]);  // set wins
      end
      assign stat_o[b] = flag_q;
    end else begin : g_rsvd
      assign stat_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_err_log_pkg::*;
#(
  parameter int GRAIN_LSB = 7
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ce_i,
  input  logic      ue_i,
  input  logic      ce_held_i,
  input  logic      ue_held_i,
  input  err_info_t info_i,
  output err_info_t info_o
);
  localparam int KEEP_W = PADDR_W - GRAIN_LSB;

  logic [KEEP_W-1:0]    addr_q;
  logic                 chan_q;
  logic [SYN_W-1:0]     syn_q;
  logic                 load;
  logic [GRAIN_LSB-1:0] addr_lo_unused;

  assign addr_lo_unused = info_i.addr[GRAIN_LSB-1:0];

  // UE may displace a CE record; CE only fills an empty record
  assign load = (ue_i & ~ue_held_i) | (ce_i & ~ce_held_i & ~ue_held_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
    end else if (load) begin
      addr_q <= info_i.addr[PADDR_W-1:GRAIN_LSB];
      chan_q <= info_i.chan;
      syn_q  <= info_i.syn;
    end
  end

  assign info_o.addr = {addr_q, {GRAIN_LSB{1'b0}}};
  assign info_o.chan = chan_q;
  assign info_o.syn  = syn_q;
endmodule

// File: rtl/ecc_err_serr.sv
module ecc_err_serr
  import ecc_err_log_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] en_i,
  output logic              serr_o
);
  logic [STAT_W-1:0] hit;
  logic              serr_q;

  for (genvar b = 0; b < STAT_W; b++) begin : g_hit
    assign hit[b] = stat_i[b] & en_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b0;
    else         serr_q <= |hit;
  end

  assign serr_o = serr_q;
endmodule

// File: rtl/ecc_err_regif.sv
module ecc_err_regif
  import ecc_err_log_pkg::*;
#(
  parameter int REG_AW    = 3,
  parameter int DATA_W    = 32,
  parameter int GRAIN_LSB = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [STAT_W-1:0] stat_i,
  input  err_info_t         info_i,
  output logic [STAT_W-1:0] clr_o,
  output logic [STAT_W-1:0] cmd_o
);
  logic [STAT_W-1:0]        cmd_q;
  logic                     wr_stat, wr_cmd;
  logic [DATA_W-1:0]        eaddr_rd, ext_rd, syn_rd;
  logic [DATA_W-STAT_W-1:0] wdata_hi_unused;
  logic [GRAIN_LSB-1:0]     info_lo_unused;

  assign wdata_hi_unused = reg_wdata_i[DATA_W-1:STAT_W];
  assign info_lo_unused  = info_i.addr[GRAIN_LSB-1:0];

  assign wr_stat = reg_wr_i && (reg_addr_i == REG_AW'(OFS_STAT));
  assign wr_cmd  = reg_wr_i && (reg_addr_i == REG_AW'(OFS_CMD));
  assign clr_o   = wr_stat ? (reg_wdata_i[STAT_W-1:0] & FLAG_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (wr_cmd) cmd_q <= reg_wdata_i[STAT_W-1:0] & FLAG_MASK;
  end
  assign cmd_o = cmd_q;

  always_comb begin
    eaddr_rd = '0;
    eaddr_rd[DATA_W-1:GRAIN_LSB] = info_i.addr[DATA_W-1:GRAIN_LSB];
    eaddr_rd[0] = info_i.chan;
    ext_rd = '0;
    ext_rd[0] = info_i.addr[PADDR_W-1];
    syn_rd = '0;
    syn_rd[SYN_W-1:0] = info_i.syn;
  end

  always_comb begin
    case (reg_addr_i)
      REG_AW'(OFS_STAT):  reg_rdata_o = DATA_W'(stat_i);
      REG_AW'(OFS_CMD):   reg_rdata_o = DATA_W'(cmd_q);
      REG_AW'(OFS_EADDR): reg_rdata_o = eaddr_rd;
      REG_AW'(OFS_EXT):   reg_rdata_o = ext_rd;
      REG_AW'(OFS_SYN):   reg_rdata_o = syn_rd;
      default:            reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int REG_AW    = 3,
  parameter int DATA_W    = 32,
  parameter int GRAIN_LSB = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               ue_i,
  input  logic [PADDR_W-1:0] err_addr_i,
  input  logic               err_chan_i,
  input  logic [SYN_W-1:0]   err_syn_i,
  input  logic               rfto_i,
  input  logic               lock_i,
  input  logic               therm_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               serr_o
);
  logic [STAT_W-1:0] set_vec, clr_vec, stat_q, cmd_q;
  err_info_t         info_in, info_q;
  logic [SYN_W-1:0]  log_syn;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_CE]    = ce_i;
    set_vec[BIT_UE]    = ue_i;
    set_vec[BIT_RFTO]  = rfto_i;
    set_vec[BIT_LOCK]  = lock_i;
    set_vec[BIT_THERM] = therm_i;
  end

  assign info_in.addr = err_addr_i;
  assign info_in.chan = err_chan_i;
  assign info_in.syn  = err_syn_i;
  assign log_syn      = info_q.syn;

  ecc_err_status u_status (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .set_i (set_vec), .clr_i (clr_vec), .stat_o (stat_q)
  );

  ecc_err_capture #(.GRAIN_LSB(GRAIN_LSB)) u_capture (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .ce_i (ce_i), .ue_i (ue_i),
    .ce_held_i (stat_q[BIT_CE]), .ue_held_i (stat_q[BIT_UE]),
    .info_i (info_in), .info_o (info_q)
  );

  ecc_err_regif #(.REG_AW(REG_AW), .DATA_W(DATA_W), .GRAIN_LSB(GRAIN_LSB)) u_regif (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .reg_addr_i (reg_addr_i), .reg_wr_i (reg_wr_i),
    .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o),
    .stat_i (stat_q), .info_i (info_q),
    .clr_o (clr_vec), .cmd_o (cmd_q)
  );

  ecc_err_serr u_serr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .stat_i (stat_q), .en_i (cmd_q), .serr_o (serr_o)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_err_log_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              ue_i,
  input logic              rfto_i,
  input logic [SYN_W-1:0]  err_syn_i,
  input logic              reg_wr_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] cmd_q,
  input logic [SYN_W-1:0]  log_syn,
  input logic              serr_o
);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~FLAG_MASK) == '0);

  assert_ue_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_i |=> stat_q[BIT_UE]);

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == REG_AW'(OFS_STAT) && reg_wdata_i[BIT_RFTO] && !rfto_i)
    |=> !stat_q[BIT_RFTO]);

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> stat_q[BIT_CE]);

  assert_ce_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !ue_i && (stat_q[BIT_CE] || stat_q[BIT_UE])) |=> $stable(log_syn));

  assert_ue_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_i && !stat_q[BIT_UE]) |=> log_syn == $past(err_syn_i));

  assert_cmd_rsvd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q & ~FLAG_MASK) == '0);

  assert_serr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> serr_o == $past(|(stat_q & cmd_q)));
endmodule

bind ecc_err_log ecc_err_log_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/ecc_err_log_tb_top.sv
module ecc_err_log_tb_top;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_i = 0, ue_i = 0, rfto_i = 0, lock_i = 0, therm_i = 0;
  logic [32:0]       err_addr_i = '0;
  logic              err_chan_i = 0;
  logic [7:0]        err_syn_i = '0;
  logic [REG_AW-1:0] reg_addr_i = '0;
  logic              reg_wr_i = 0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;
  logic              serr_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] d;

  always #10 clk_i = ~clk_i;  // 50 MHz

  ecc_err_log dut_i (.*);

  typedef struct packed {
    logic        clr;
    logic        ce;
    logic        ue;
    logic [32:0] addr;
    logic        ch;
    logic [7:0]  syn;
    logic [15:0] st;
    logic [31:0] ea;
    logic [31:0] ext;
    logic [31:0] sy;
  } vec_t;

  // R8/R9 ordering sequence; clr=1 clears all flags first
  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 1'b0, 33'h1_2345_67FF, 1'b1, 8'h5A, 16'h0001, 32'h2345_6781, 32'h1, 32'h5A},
    '{1'b0, 1'b1, 1'b0, 33'h0_0000_1080, 1'b0, 8'h11, 16'h0001, 32'h2345_6781, 32'h1, 32'h5A},
    '{1'b0, 1'b0, 1'b1, 33'h0_ABCD_EF00, 1'b0, 8'hC3, 16'h0003, 32'hABCD_EF00, 32'h0, 32'hC3},
    '{1'b0, 1'b0, 1'b1, 33'h1_1111_1111, 1'b1, 8'h77, 16'h0003, 32'hABCD_EF00, 32'h0, 32'hC3},
    '{1'b1, 1'b1, 1'b0, 33'h0_0000_007F, 1'b1, 8'h01, 16'h0001, 32'h0000_0001, 32'h0, 32'h01},
    '{1'b0, 1'b0, 1'b1, 33'h1_FFFF_FFFF, 1'b0, 8'hFE, 16'h0003, 32'hFFFF_FF80, 32'h1, 32'hFE}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = v; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic ev(input logic ce, input logic ue, input logic [32:0] ad,
                    input logic ch, input logic [7:0] sy);
    @(negedge clk_i);
    ce_i = ce; ue_i = ue; err_addr_i = ad; err_chan_i = ch; err_syn_i = sy;
    @(negedge clk_i);
    ce_i = 0; ue_i = 0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(REG_AW'(a), d);
      check("R1 reg after reset", d, 32'h0);
    end
    check("R1 serr after reset", {31'b0, serr_o}, 32'h0);

    // R5 R6 R7 R8 R9 table walk
    for (int i = 0; i < 6; i++) begin
      if (VECS[i].clr) wr(3'd0, 32'h0000_FFFF);
      ev(VECS[i].ce, VECS[i].ue, VECS[i].addr, VECS[i].ch, VECS[i].syn);
      rd(3'd0, d); check("R2 R8 R9 status", d, {16'h0, VECS[i].st});
      rd(3'd2, d); check("R5 R8 R9 address", d, VECS[i].ea);
      rd(3'd3, d); check("R6 extended address", d, VECS[i].ext);
      rd(3'd4, d); check("R7 syndrome", d, VECS[i].sy);
    end

    // R12 writes to record registers ignored
    wr(3'd2, 32'h1234_5678); wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'h0000_0033);
    rd(3'd2, d); check("R12 address unchanged", d, 32'hFFFF_FF80);
    rd(3'd3, d); check("R12 ext unchanged", d, 32'h1);
    rd(3'd4, d); check("R12 syndrome unchanged", d, 32'hFE);

    // R3 partial clear: clear bit 0 only
    wr(3'd0, 32'h0000_0001);
    rd(3'd0, d); check("R3 write-0 keeps, write-1 clears", d, 32'h0002);

    // R2 other event bits, reserved stay 0
    @(negedge clk_i); rfto_i = 1; lock_i = 1; therm_i = 1;
    @(negedge clk_i); rfto_i = 0; lock_i = 0; therm_i = 0;
    rd(3'd0, d); check("R2 event bits", d, 32'h0B02);
    wr(3'd0, 32'h0000_F4FC);
    rd(3'd0, d); check("R2 reserved-bit write no effect", d, 32'h0B02);
    wr(3'd0, 32'h0000_FFFF);
    rd(3'd0, d); check("R3 full clear", d, 32'h0);

    // R4 same-cycle set and clear
    @(negedge clk_i); rfto_i = 1;
    @(negedge clk_i); rfto_i = 0;
    @(negedge clk_i);
    reg_addr_i = 3'd0; reg_wdata_i = 32'h0100; reg_wr_i = 1; rfto_i = 1;
    @(negedge clk_i); reg_wr_i = 0; rfto_i = 0;
    rd(3'd0, d); check("R4 set wins over clear", d, 32'h0100);
    wr(3'd0, 32'h0000_FFFF);

    // R10 command register
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R10 command writable bits", d, 32'h0B03);
    wr(3'd1, 32'h0000_0100);
    rd(3'd1, d); check("R10 command readback", d, 32'h0100);

    // R11 serr timing and masking
    @(negedge clk_i); lock_i = 1;
    @(negedge clk_i); lock_i = 0;
    repeat (2) @(negedge clk_i);
    #1 check("R11 disabled flag no serr", {31'b0, serr_o}, 32'h0);
    @(negedge clk_i); rfto_i = 1;
    @(negedge clk_i); rfto_i = 0;
    #1 check("R11 serr low in flag cycle", {31'b0, serr_o}, 32'h0);
    @(negedge clk_i);
    #1 check("R11 serr one cycle later", {31'b0, serr_o}, 32'h1);
    wr(3'd0, 32'h0000_0100);
    #1 check("R11 serr held in clear cycle", {31'b0, serr_o}, 32'h1);
    @(negedge clk_i);
    #1 check("R11 serr drops after clear", {31'b0, serr_o}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule